// File: doc/BRIEF.md
# Stage-Select Binary Timer

This block is a synchronous 24-stage binary divider. The divider steps on falling transitions of a slow count input, which is sampled by the system clock. A 4-bit stage code, together with a skip input, chooses which stage drives a single timer output. The output therefore toggles at the input rate divided by a power of two. Preset and clear controls reach the block asynchronously and are synchronised inside it. Preset forces the output high through a separate conditioning latch. The next falling input edge pulls the output low, and the divider runs from the edge after that. This gives a defined start point for a timed interval.

A hold input freezes the divider while the input keeps toggling. An oscillator-enable output tells a clock source outside the block when it may run. A split mode, entered with skip, preset and clear all high, breaks the divider into three 8-stage sections that count in parallel. This lets every stage be driven to one in 255 input edges. When preset and clear are then released together, a single further edge rolls the whole chain back to zero.

Top module: `stage_timer`

## Requirements
- R1: The divider changes only on a high-to-low transition of `cnt_in`. Outside the split and skip modes, each such transition adds one to `count_o`. A rising transition, or no transition, leaves `count_o` unchanged.
- R2: With `skip_i` low, `tick_o` equals bit 8+`sel_i` of `count_o`, with `sel_i` read as an unsigned number. Codes 0 to 15 therefore pick stages 9 to 24 (bits 8 to 23), and code c divides the input by 2^(9+c).
- R3: With `skip_i` high, falling input edges add one to bits 23:8 while bits 7:0 stay unchanged. `tick_o` is still bit 8+`sel_i`, so code c divides the input by 2^(c+1).
- R4: While `clr_i` is high, outside split mode, all stages are cleared and `tick_o` is low. This includes the case where `preset_i` is high and `skip_i` is low, so clear wins over preset.
- R5: While `preset_i` is high and `clr_i` is low, all stages are cleared and `tick_o` is high.
- R6: After `preset_i` falls, the first falling input edge drives `tick_o` low without changing `count_o`. The second falling edge is the first one that counts.
- R7: While `hold_i` is high, falling input edges change neither `count_o` nor `tick_o`. Once `hold_i` is low again, the next falling edge counts.
- R8: `osc_en_o` is low while `preset_i` or `clr_i` is high. Otherwise it is the inverse of `osc_off_i`.
- R9: With `skip_i`, `preset_i` and `clr_i` all high, each falling edge adds one to each of the three 8-bit sections (bits 7:0, 15:8 and 23:16) independently. After 255 edges every stage is 1.
- R10: When `preset_i` and `clr_i` fall together out of split mode, the chain keeps its value and becomes one serial counter again. From all ones, one falling edge with `skip_i` low gives all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | System reset, active low, asynchronous |
| cnt_in | input | 1 | Count input, sampled; falling transitions advance the divider |
| preset_i | input | 1 | Preset control: output latch high, stages cleared |
| clr_i | input | 1 | Clear control: output low, stages cleared |
| skip_i | input | 1 | Skip the first eight stages; with preset and clear high, selects split mode |
| hold_i | input | 1 | Freeze the divider |
| osc_off_i | input | 1 | Request to stop the external clock source |
| sel_i | input | 4 | Stage code for the timer output |
| count_o | output | 24 | Divider stages, bit 0 first |
| tick_o | output | 1 | Timer output |
| osc_en_o | output | 1 | Clock source enable |

## Verification
The hardest state to reach is the all-ones chain followed by a serial rollover. It needs split mode, then 255 input edges, then preset and clear released on the same clock while skip stays high. Skip may only drop after that release has passed the synchroniser. If skip drops too early, the block briefly sees clear-without-split and wipes the chain. The bench therefore sequences these controls a full synchroniser delay apart, and checks every section after each of the 255 edges before it applies the rollover edge.

// File: rtl/stage_timer_pkg.sv
package stage_timer_pkg;

    typedef enum logic [1:0] {
        MODE_RUN,
        MODE_CLEAR,
        MODE_PRESET,
        MODE_SPLIT
    } mode_e;

    typedef struct packed {
        logic latch;
        logic prev;
        logic osc_en;
    } ctl_t;

endpackage

// File: rtl/sync_bank.sv
module sync_bank #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] s1_d, s1_q, s2_d, s2_q;

    always_comb begin
        s1_d = d_i;
        s2_d = s1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign q_o = s2_q;
endmodule

// File: rtl/stage_chain.sv
module stage_chain #(
    parameter int STAGES = 24,
    parameter int SECT   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              adv_i,
    input  logic              skip_i,
    input  logic              test_i,
    output logic [STAGES-1:0] chain_o
);
    localparam int NSEC = STAGES / SECT;
    localparam int HI   = STAGES - SECT;

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        if (clear_i) begin
            chain_d = '0;
        end else if (adv_i) begin
            if (test_i) begin
                for (int s = 0; s < NSEC; s++) begin
                    chain_d[s*SECT +: SECT] = chain_q[s*SECT +: SECT] + SECT'(1);
                end
            end else if (skip_i) begin
                chain_d[STAGES-1:SECT] = chain_q[STAGES-1:SECT] + HI'(1);
            end else begin
                chain_d = chain_q + STAGES'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign chain_o = chain_q;
endmodule

// File: rtl/stage_pick.sv
module stage_pick #(
    parameter int STAGES = 24,
    parameter int SECT   = 8,
    parameter int SEL_W  = 4
) (
    input  logic [STAGES-1:0] chain_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic              bit_o
);
    localparam int IDX_W = $clog2(STAGES);

    logic [IDX_W-1:0] idx;

    always_comb begin
        idx   = IDX_W'(SECT) + IDX_W'(sel_i);
        bit_o = chain_i[idx];
    end
endmodule

// File: rtl/stage_timer.sv
module stage_timer
    import stage_timer_pkg::*;
#(
    parameter int STAGES = 24,
    parameter int SECT   = 8,
    parameter int SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_in,
    input  logic              preset_i,
    input  logic              clr_i,
    input  logic              skip_i,
    input  logic              hold_i,
    input  logic              osc_off_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic [STAGES-1:0] count_o,
    output logic              tick_o,
    output logic              osc_en_o
);
    logic [2:0] sync_v;
    logic       cnt_s, set_s, rst_s;
    logic       fall, clear, adv, test, pick_bit;
    mode_e      mode;
    ctl_t       ctl_d, ctl_q;

    sync_bank #(.W(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cnt_in, preset_i, clr_i}),
        .q_o   (sync_v)
    );

    assign cnt_s = sync_v[2];
    assign set_s = sync_v[1];
    assign rst_s = sync_v[0];

    always_comb begin
        if (set_s && rst_s && skip_i) mode = MODE_SPLIT;
        else if (rst_s)               mode = MODE_CLEAR;
        else if (set_s)               mode = MODE_PRESET;
        else                          mode = MODE_RUN;

        test  = (mode == MODE_SPLIT);
        fall  = ctl_q.prev & ~cnt_s;
        clear = (mode == MODE_CLEAR) || (mode == MODE_PRESET);
        adv   = fall & ~hold_i & (test | ((mode == MODE_RUN) & ~ctl_q.latch));

        ctl_d        = ctl_q;
        ctl_d.prev   = cnt_s;
        ctl_d.osc_en = ~(set_s | rst_s | osc_off_i);
        case (mode)
            MODE_SPLIT:  ctl_d.latch = 1'b0;
            MODE_CLEAR:  ctl_d.latch = 1'b0;
            MODE_PRESET: ctl_d.latch = 1'b1;
            default: if (fall && !hold_i) ctl_d.latch = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    stage_chain #(.STAGES(STAGES), .SECT(SECT)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear),
        .adv_i   (adv),
        .skip_i  (skip_i),
        .test_i  (test),
        .chain_o (count_o)
    );

    stage_pick #(.STAGES(STAGES), .SECT(SECT), .SEL_W(SEL_W)) u_pick (
        .chain_i (count_o),
        .sel_i   (sel_i),
        .bit_o   (pick_bit)
    );

    assign tick_o   = ctl_q.latch | pick_bit;
    assign osc_en_o = ctl_q.osc_en;
endmodule

// File: rtl/stage_timer_chk.sv
module stage_timer_chk #(
    parameter int STAGES = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              set_s,
    input logic              rst_s,
    input logic              fall,
    input logic              hold_i,
    input logic              skip_i,
    input logic              latch_q,
    input logic [STAGES-1:0] count_o,
    input logic              tick_o,
    input logic              osc_en_o
);
    AST_NO_EDGE_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall && !set_s && !rst_s) |=> $stable(count_o)); // R1

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_s && !(set_s && skip_i)) |=> (count_o == '0 && !tick_o)); // R4

    AST_PRESET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (set_s && !rst_s) |=> (count_o == '0 && tick_o)); // R5

    AST_FIRST_EDGE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_s && !rst_s && latch_q && fall && !hold_i) |=> (!latch_q && $stable(count_o))); // R6

    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_s && !rst_s && hold_i) |=> $stable(count_o)); // R7

    AST_OSC_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (set_s || rst_s) |=> !osc_en_o); // R8
endmodule

bind stage_timer stage_timer_chk #(.STAGES(STAGES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_s    (set_s),
    .rst_s    (rst_s),
    .fall     (fall),
    .hold_i   (hold_i),
    .skip_i   (skip_i),
    .latch_q  (ctl_q.latch),
    .count_o  (count_o),
    .tick_o   (tick_o),
    .osc_en_o (osc_en_o)
);

// File: tb/sim_stage_timer.sv
`timescale 1ns/1ps
module sim_stage_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_in = 1'b0;
    logic        preset_i = 1'b0;
    logic        clr_i = 1'b0;
    logic        skip_i = 1'b0;
    logic        hold_i = 1'b0;
    logic        osc_off_i = 1'b0;
    logic [3:0]  sel_i = 4'd0;
    logic [23:0] count_o;
    logic        tick_o;
    logic        osc_en_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    stage_timer u0 (
        .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .preset_i(preset_i),
        .clr_i(clr_i), .skip_i(skip_i), .hold_i(hold_i), .osc_off_i(osc_off_i),
        .sel_i(sel_i), .count_o(count_o), .tick_o(tick_o), .osc_en_o(osc_en_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fall_one();
        cnt_in = 1'b1;
        wait_n(4);
        cnt_in = 1'b0;
        wait_n(4);
    endtask

    task automatic sweep_sel(input logic [23:0] exp_cnt, input string req);
        for (int c = 0; c < 16; c++) begin
            sel_i = 4'(c);
            #0.1;
            chk(tick_o == exp_cnt[8 + c], req, 32'(tick_o), 32'(exp_cnt[8 + c]));
        end
        sel_i = 4'd0;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [23:0] e;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(4);
        // reset state
        chk(count_o == 24'd0, "R4 reset state count", 32'(count_o), 0);
        chk(tick_o == 1'b0, "R4 reset state tick", 32'(tick_o), 0);
        chk(osc_en_o == 1'b1, "R8 idle enable", 32'(osc_en_o), 1);

        // R8 oscillator enable
        osc_off_i = 1'b1; wait_n(2);
        chk(osc_en_o == 1'b0, "R8 osc_off", 32'(osc_en_o), 0);
        osc_off_i = 1'b0; clr_i = 1'b1; wait_n(4);
        chk(osc_en_o == 1'b0, "R8 clear stops", 32'(osc_en_o), 0);
        clr_i = 1'b0; preset_i = 1'b1; wait_n(4);
        chk(osc_en_o == 1'b0, "R8 preset stops", 32'(osc_en_o), 0);
        preset_i = 1'b0; clr_i = 1'b1; wait_n(4);
        clr_i = 1'b0; wait_n(4);
        chk(osc_en_o == 1'b1, "R8 released", 32'(osc_en_o), 1);

        // R1 and R2: serial count, no skip
        for (int f = 1; f <= 600; f++) begin
            cnt_in = 1'b1;
            wait_n(4);
            if (f <= 4) chk(count_o == 24'(f - 1), "R1 rise no count", 32'(count_o), 32'(f - 1));
            cnt_in = 1'b0;
            wait_n(4);
            chk(count_o == 24'(f), "R1 fall count", 32'(count_o), 32'(f));
            if (f % 50 == 0 || f == 256 || f == 512 || f == 511) sweep_sel(24'(f), "R2 stage select");
        end

        // R7 hold
        hold_i = 1'b1;
        for (int k = 0; k < 5; k++) fall_one();
        chk(count_o == 24'd600, "R7 hold count", 32'(count_o), 600);
        sweep_sel(24'd600, "R7 hold tick");
        hold_i = 1'b0;
        fall_one();
        chk(count_o == 24'd601, "R7 resume", 32'(count_o), 601);

        // R4 clear
        clr_i = 1'b1; wait_n(4);
        chk(count_o == 24'd0 && tick_o == 1'b0, "R4 clear", 32'(count_o), 0);
        clr_i = 1'b0; wait_n(4);

        // R3 skip mode
        skip_i = 1'b1;
        for (int f = 1; f <= 70; f++) begin
            fall_one();
            e = 24'(f) << 8;
            chk(count_o == e, "R3 skip count", 32'(count_o), 32'(e));
            for (int c = 0; c < 16; c++) begin
                sel_i = 4'(c);
                #0.1;
                chk(tick_o == ((f >> c) & 1), "R3 skip divide", 32'(tick_o), 32'((f >> c) & 1));
            end
            sel_i = 4'd0;
        end
        skip_i = 1'b0;

        // R5 and R6 preset and restart
        preset_i = 1'b1; wait_n(4);
        chk(tick_o == 1'b1, "R5 preset tick", 32'(tick_o), 1);
        chk(count_o == 24'd0, "R5 preset clears", 32'(count_o), 0);
        preset_i = 1'b0; wait_n(4);
        chk(tick_o == 1'b1, "R6 held after release", 32'(tick_o), 1);
        fall_one();
        chk(tick_o == 1'b0, "R6 first edge low", 32'(tick_o), 0);
        chk(count_o == 24'd0, "R6 first edge no count", 32'(count_o), 0);
        fall_one();
        chk(count_o == 24'd1, "R6 second edge counts", 32'(count_o), 1);

        // R4 clear wins over preset without skip
        preset_i = 1'b1; clr_i = 1'b1; wait_n(4);
        chk(tick_o == 1'b0, "R4 priority tick", 32'(tick_o), 0);
        chk(count_o == 24'd0, "R4 priority count", 32'(count_o), 0);
        fall_one();
        chk(count_o == 24'd0, "R4 no count in clear", 32'(count_o), 0);
        preset_i = 1'b0; clr_i = 1'b0; wait_n(4);

        // R9 split mode
        skip_i = 1'b1; wait_n(1);
        preset_i = 1'b1; clr_i = 1'b1; wait_n(4);
        chk(count_o == 24'd0, "R9 split start", 32'(count_o), 0);
        for (int f = 1; f <= 255; f++) begin
            fall_one();
            e = {8'(f), 8'(f), 8'(f)};
            chk(count_o == e, "R9 split sections", 32'(count_o), 32'(e));
        end
        chk(count_o == 24'hFFFFFF, "R9 all ones", 32'(count_o), 32'hFFFFFF);

        // R10 return to serial and roll over
        preset_i = 1'b0; clr_i = 1'b0; wait_n(4);
        chk(count_o == 24'hFFFFFF, "R10 kept on exit", 32'(count_o), 32'hFFFFFF);
        skip_i = 1'b0; wait_n(2);
        fall_one();
        chk(count_o == 24'd0, "R10 rollover", 32'(count_o), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule